// File: doc/BRIEF.md
# Partitioned Lane Add, Subtract and Compare Unit

This block is a small SIMD integer unit. It treats a 64-bit word as a row of independent lanes, either 16 or 32 bits wide. In each lane it can add, subtract, or compare. Arithmetic wraps inside each lane. A compare gives one flag bit per lane, and the flags are packed into the low bits of an otherwise zero result.

The arithmetic operations also have a short form. The short form reads only the low 32 bits of each operand and returns zero in the upper half of the result. The unit takes one request per cycle with a valid strobe and returns the registered result one cycle later. A media or vector pipeline can use it as one execution slot.

Top module: `lane_alu`

## Requirements
- R1: With opSel = 0 (add), each lane of the result is laneB + laneA modulo 2^laneWidth. No carry crosses from one lane into the next.
- R2: With opSel = 1 (subtract), each lane of the result is laneB − laneA modulo 2^laneWidth. The operand order matters and is not swapped.
- R3: wideLanes = 0 selects 16-bit lanes, with lane i at bits [16i+15:16i]. wideLanes = 1 selects 32-bit lanes, with lane i at bits [32i+31:32i]. The same operands give different sums when a carry would cross a 16-bit boundary.
- R4: With shortForm = 1 on add or subtract, only bits [31:0] of each operand take part. Bits [63:32] of the result are zero. That leaves two 16-bit lanes or one 32-bit lane.
- R5: opSel = 4, 5, 6 and 7 compare laneB against laneA as signed two's-complement values, testing greater-than, equal, less-or-equal and not-equal respectively. Result bit i is 1 when lane i meets the test. The result is 4 bits for 16-bit lanes and 2 bits for 32-bit lanes, and all higher result bits are zero.
- R6: shortForm has no effect on a compare. The result is the same full-width mask as with shortForm = 0.
- R7: outValid is high exactly one cycle after a cycle with inValid high. The result updates only on such cycles and otherwise keeps its last value.
- R8: Reset (rstN low) clears outValid and the result to zero.
- R9: The unused opcodes 2 and 3 produce an all-zero result, which is still flagged valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| inValid | input | 1 | Request strobe |
| opSel | input | 3 | Operation code (see R1, R2, R5, R9) |
| wideLanes | input | 1 | 0: 16-bit lanes, 1: 32-bit lanes |
| shortForm | input | 1 | 1: 32-bit operand form for add and subtract |
| opA | input | 64 | Operand A |
| opB | input | 64 | Operand B |
| outValid | output | 1 | Result valid, one cycle after inValid |
| result | output | 64 | Registered result |

## Verification
The bench sweeps every opcode under both lane widths and both operand forms. Lane values are built from the signed extremes (0, 1, 0x7FFF, 0x8000, 0xFFFF) and from pseudo-random words. These values expose the typical faults:
- A carry chain that leaks between lanes gives off-by-one upper lanes.
- Operands swapped in subtract give negated lanes.
- An unsigned compare flips its flags wherever 0x8000 meets 0x7FFF.
- A mask placed at the wrong bit shows the wrong lane order.

Short-form checks catch upper-half garbage, and they catch a compare wrongly cut down to the low half. Idle cycles with changed operands catch a result register that loads without a request.

// File: rtl/lane_alu_pkg.sv
package lane_alu_pkg;

  localparam int OP_W = 3;

  localparam logic [1:0] PRED_GT = 2'd0;
  localparam logic [1:0] PRED_EQ = 2'd1;
  localparam logic [1:0] PRED_LE = 2'd2;
  localparam logic [1:0] PRED_NE = 2'd3;

  typedef struct packed {
    logic       load;
    logic       doArith;
    logic       doSub;
    logic       doCmp;
    logic [1:0] pred;
    logic       wide;
    logic       shortArith;
  } ctrlStrobes_t;

endpackage

// File: rtl/lane_alu_ctrl.sv
module lane_alu_ctrl
  import lane_alu_pkg::*;
(
  input  logic              inValid,
  input  logic [OP_W-1:0]   opSel,
  input  logic              wideLanes,
  input  logic              shortForm,
  output ctrlStrobes_t      strb
);

  always_comb begin
    strb.load       = inValid;
    strb.doCmp      = opSel[2];
    strb.doArith    = ~opSel[2] & ~opSel[1];
    strb.doSub      = ~opSel[2] & ~opSel[1] & opSel[0];
    strb.pred       = opSel[1:0];
    strb.wide       = wideLanes;
    // the short form only narrows add and subtract
    strb.shortArith = shortForm & ~opSel[2] & ~opSel[1];
  end

endmodule

// File: rtl/lane_alu_dp.sv
module lane_alu_dp
  import lane_alu_pkg::*;
#(
  parameter int DATA_W = 64
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobes_t      strb,
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  output logic              validQ,
  output logic [DATA_W-1:0] resultQ
);

  localparam int NARROW_W = 16;
  localparam int WIDE_W   = 32;
  localparam int N16      = DATA_W / NARROW_W;
  localparam int N32      = DATA_W / WIDE_W;
  localparam int HALF     = DATA_W / 2;

  logic [DATA_W-1:0] arith16, arith32;
  logic [N16-1:0]    cmp16;
  logic [N32-1:0]    cmp32;
  logic [DATA_W-1:0] nextRes;

  function automatic logic predHit(input logic [1:0] p, input logic gt, input logic eq);
    case (p)
      PRED_GT: predHit = gt;
      PRED_EQ: predHit = eq;
      PRED_LE: predHit = ~gt;
      default: predHit = ~eq;
    endcase
  endfunction

  for (genvar i = 0; i < N16; i++) begin : g_narrow
    logic [NARROW_W-1:0] laneA, laneB, laneRes;
    logic                gtHit, eqHit;
    assign laneA   = opA[i*NARROW_W +: NARROW_W];
    assign laneB   = opB[i*NARROW_W +: NARROW_W];
    assign laneRes = strb.doSub ? laneB - laneA : laneB + laneA;
    assign gtHit   = $signed(laneB) > $signed(laneA);
    assign eqHit   = laneB == laneA;
    assign cmp16[i] = predHit(strb.pred, gtHit, eqHit);
    if (i >= N16 / 2) begin : g_hi
      assign arith16[i*NARROW_W +: NARROW_W] = strb.shortArith ? '0 : laneRes;
    end else begin : g_lo
      assign arith16[i*NARROW_W +: NARROW_W] = laneRes;
    end
  end

  for (genvar j = 0; j < N32; j++) begin : g_wide
    logic [WIDE_W-1:0] laneA, laneB, laneRes;
    logic              gtHit, eqHit;
    assign laneA   = opA[j*WIDE_W +: WIDE_W];
    assign laneB   = opB[j*WIDE_W +: WIDE_W];
    assign laneRes = strb.doSub ? laneB - laneA : laneB + laneA;
    assign gtHit   = $signed(laneB) > $signed(laneA);
    assign eqHit   = laneB == laneA;
    assign cmp32[j] = predHit(strb.pred, gtHit, eqHit);
    if (j >= N32 / 2) begin : g_hi
      assign arith32[j*WIDE_W +: WIDE_W] = strb.shortArith ? '0 : laneRes;
    end else begin : g_lo
      assign arith32[j*WIDE_W +: WIDE_W] = laneRes;
    end
  end

  always_comb begin
    if (strb.doArith)
      nextRes = strb.wide ? arith32 : arith16;
    else if (strb.doCmp)
      nextRes = strb.wide ? {{(DATA_W-N32){1'b0}}, cmp32} : {{(DATA_W-N16){1'b0}}, cmp16};
    else
      nextRes = '0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      validQ  <= 1'b0;
      resultQ <= '0;
    end else begin
      validQ <= strb.load;
      if (strb.load) resultQ <= nextRes;
    end
  end

  p_valid_follow_r7: assert property (@(posedge clk) disable iff (!rstN)
    strb.load |=> validQ);

  p_hold_idle_r7: assert property (@(posedge clk) disable iff (!rstN)
    !strb.load |=> $stable(resultQ));

  p_short_upper_zero_r4: assert property (@(posedge clk) disable iff (!rstN)
    strb.load && strb.shortArith |=> resultQ[DATA_W-1:HALF] == '0);

  p_mask_zext_r5: assert property (@(posedge clk) disable iff (!rstN)
    strb.load && strb.doCmp |=> resultQ[DATA_W-1:N16] == '0);

  p_unused_zero_r9: assert property (@(posedge clk) disable iff (!rstN)
    strb.load && !strb.doArith && !strb.doCmp |=> resultQ == '0);

endmodule

// File: rtl/lane_alu.sv
module lane_alu
  import lane_alu_pkg::*;
#(
  parameter int DATA_W = 64
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic [2:0]        opSel,
  input  logic              wideLanes,
  input  logic              shortForm,
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  output logic              outValid,
  output logic [DATA_W-1:0] result
);

  ctrlStrobes_t strb;

  lane_alu_ctrl u_ctrl (
    .inValid   (inValid),
    .opSel     (opSel),
    .wideLanes (wideLanes),
    .shortForm (shortForm),
    .strb      (strb)
  );

  lane_alu_dp #(.DATA_W(DATA_W)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strb    (strb),
    .opA     (opA),
    .opB     (opB),
    .validQ  (outValid),
    .resultQ (result)
  );

  p_idle_low_r7: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> !outValid);

endmodule

// File: tb/lane_alu_test.sv
`timescale 1ns/1ps
module lane_alu_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic [2:0]  opSel = '0;
  logic        wideLanes = 1'b0;
  logic        shortForm = 1'b0;
  logic [63:0] opA = '0;
  logic [63:0] opB = '0;
  logic        outValid;
  logic [63:0] result;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  logic [63:0] lfsr = 64'hACE1_2468_1357_BEEF;

  always #2.5 clk = ~clk;

  lane_alu uut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .opSel(opSel),
    .wideLanes(wideLanes), .shortForm(shortForm),
    .opA(opA), .opB(opB), .outValid(outValid), .result(result)
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles == 150000) begin
      errors++;
      $display("FAIL watchdog: run did not finish, got %0d cycles expected fewer", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  function automatic logic [63:0] nextRand(input logic [63:0] s);
    return {s[62:0], s[63] ^ s[62] ^ s[60] ^ s[59]};
  endfunction

  // arithmetic reference built from the requirements
  function automatic logic [63:0] model(input logic [2:0] op, input logic wd,
                                        input logic sh, input logic [63:0] a,
                                        input logic [63:0] b);
    logic [63:0] r = '0;
    int lw = wd ? 32 : 16;
    logic [63:0] mask = wd ? 64'hFFFF_FFFF : 64'hFFFF;
    if (op[2]) begin
      for (int i = 0; i < 64 / lw; i++) begin
        longint x, y;
        logic hit;
        if (wd) begin
          x = longint'($signed(b[i*32 +: 32])); y = longint'($signed(a[i*32 +: 32]));
        end else begin
          x = longint'($signed(b[i*16 +: 16])); y = longint'($signed(a[i*16 +: 16]));
        end
        case (op[1:0])
          2'd0: hit = x > y;
          2'd1: hit = x == y;
          2'd2: hit = x <= y;
          default: hit = x != y;
        endcase
        r[i] = hit;
      end
    end else if (op[1] == 1'b0) begin
      for (int i = 0; i < (sh ? 32 : 64) / lw; i++) begin
        logic [63:0] av, bv, t;
        av = (a >> (i*lw)) & mask;
        bv = (b >> (i*lw)) & mask;
        t = op[0] ? bv - av : bv + av;
        r = r | ((t & mask) << (i*lw));
      end
    end
    return r;
  endfunction

  function automatic string tagOf(input logic [2:0] op, input logic sh);
    if (op[2]) return sh ? "R6" : "R5";
    if (op[1]) return "R9";
    if (sh) return "R4";
    return op[0] ? "R2" : "R1";
  endfunction

  task automatic check64(input string tag, input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  // one request, then one idle cycle with changed operands
  task automatic runOp(input logic [2:0] op, input logic wd, input logic sh,
                       input logic [63:0] a, input logic [63:0] b);
    logic [63:0] exp;
    exp = model(op, wd, sh, a, b);
    @(negedge clk);
    inValid = 1'b1; opSel = op; wideLanes = wd; shortForm = sh; opA = a; opB = b;
    @(negedge clk);
    check64(tagOf(op, sh), result, exp);
    check64("R7 valid", {63'd0, outValid}, 64'd1);
    inValid = 1'b0; opA = ~a; opB = b ^ 64'h5555; opSel = op ^ 3'd1;
    @(negedge clk);
    check64("R7 hold", result, exp);
    check64("R7 idle", {63'd0, outValid}, 64'd0);
  endtask

  logic [15:0] corner [5];

  initial begin
    corner[0] = 16'h0000; corner[1] = 16'h0001; corner[2] = 16'h7FFF;
    corner[3] = 16'h8000; corner[4] = 16'hFFFF;

    // R8: reset state
    #1;
    check64("R8 result", result, 64'd0);
    check64("R8 valid", {63'd0, outValid}, 64'd0);
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check64("R8 after release", result, 64'd0);

    // R3: carry at the 16-bit boundary depends on lane width
    runOp(3'd0, 1'b0, 1'b0, 64'h0000_FFFF_0000_FFFF, 64'h0000_0001_0000_0001);
    runOp(3'd0, 1'b1, 1'b0, 64'h0000_FFFF_0000_FFFF, 64'h0000_0001_0000_0001);
    check64("R3 wide carry", result, 64'h0001_0000_0001_0000);

    // R9: unused opcodes
    runOp(3'd2, 1'b0, 1'b0, 64'h1234, 64'h5678);
    runOp(3'd3, 1'b1, 1'b1, 64'hFFFF, 64'hFFFF);

    // sweep of opcodes, lane widths and forms
    for (int op = 0; op < 8; op++) begin
      for (int wd = 0; wd < 2; wd++) begin
        for (int sh = 0; sh < 2; sh++) begin
          for (int it = 0; it < 96; it++) begin
            logic [63:0] a, b;
            if (it < 50) begin
              for (int k = 0; k < 4; k++) begin
                a[k*16 +: 16] = corner[(it + k) % 5];
                b[k*16 +: 16] = corner[((it / 5) + 2*k) % 5];
              end
              if (it >= 25) a = b;
            end else begin
              lfsr = nextRand(lfsr); a = lfsr;
              lfsr = nextRand(lfsr); b = lfsr;
            end
            runOp(3'(op), 1'(wd), 1'(sh), a, b);
          end
        end
      end
    end

    // R6: a compare with shortForm must still see the upper lanes
    runOp(3'd5, 1'b0, 1'b1, 64'h0005_0006_0007_0008, 64'h0005_0006_0000_0000);
    check64("R6 upper lanes", result, 64'hC);

    // R8: reset mid-run clears the registered result
    runOp(3'd0, 1'b0, 1'b0, 64'h1, 64'h1);
    @(negedge clk);
    rstN = 1'b0;
    #1;
    check64("R8 mid reset result", result, 64'd0);
    check64("R8 mid reset valid", {63'd0, outValid}, 64'd0);
    @(negedge clk);
    rstN = 1'b1;

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule